// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block measures the rotation speed of three fans. Each tachometer input is synchronised, cleaned of short glitches, and its rising edges are used to time one full tach period. The timing is done in ticks of a 90 kHz reference, supplied as a single-cycle enable derived from the system clock. The finished period count for each fan sits in a holding register. Software converts it to rpm as 5,400,000 divided by the count. A fan that stops, or is not connected, drives its count to the all-ones value 0xFFFF, and software treats that value as invalid.

Software reaches the counts through a small indexed register file in the runtime space. It writes a register number to the index port at offset 0x70, then reads the selected byte from the data port at offset 0x71. Each count is split into a low byte and a high byte. Reading the low byte also latches the high byte into a per-fan shadow register, so a low read followed by a high read always returns one coherent 16-bit value.

Top module: `fan_tach_monitor`

## Requirements
- R1: After a synchronous active-low reset, `reg_rdata` is 0x00, the index register is 0x00, every held count reads 0xFFFF, and every shadow high byte reads 0xFF.
- R2: A write with `reg_addr` = 0x70 loads `reg_wdata` into the index register. A read at 0x70 returns the index. A read at 0x71 returns the monitor register that the index selects.
- R3: Fan k (k = 0, 1, 2) has its low count byte at index 0x28+2k and its high byte at index 0x29+2k. The held count equals the number of tick-enabled cycles from one qualified rising tach edge up to the next one. The cycle of the opening edge is counted and the cycle of the closing edge is not.
- R4: The period counter advances only in cycles where `tick_en` is 1. With a tick every fourth clock, a period of P clocks (P a multiple of 4) reads as P/4.
- R5: Without a qualified edge, the counter stops at 0xFFFF and does not wrap. Once it reaches 0xFFFF, the held count also becomes 0xFFFF.
- R6: Each tach input passes through a two-flop synchroniser and then a filter. The filter accepts a new level only after 3 consecutive clocks at that level. A pulse of 2 clocks or fewer does not restart the counter or change the held count.
- R7: A data-port read of a low-byte index copies that fan's current high byte into its shadow register. A read of the high-byte index returns the shadow, not the live count.
- R8: Reads of unimplemented indices, and reads at any offset other than 0x70 or 0x71, return 0x00. Writes to the data port change no register.
- R9: `reg_rdata` updates on the clock edge where `reg_rd` is 1, and it holds its value in every cycle where `reg_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | 90 kHz reference enable, one clock wide |
| tach_in | input | 3 | Asynchronous tach inputs, one per fan |
| reg_addr | input | 8 | Runtime offset of the access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |

## Verification
Each fan is driven with a distinct steady period, and the tick is applied both on every clock and on every fourth clock. These runs separate correct tick gating from counting raw clocks, and separate per-fan decoding from swapped channels. Short pulses of two clocks, set against pulses long enough to qualify, tell the glitch filter apart from a plain edge detector. A fan held low long enough to hit 0xFFFF shows saturation as opposed to wrap-around. A period change made between a low read and a high read shows whether the shadow latch is used or the live count leaks through.

// File: rtl/fan_tach_pkg.sv
// Shared constants for the fan tachometer monitor.
// Assumes byte-wide register access and counts exactly two bytes wide.
package fan_tach_pkg;
    localparam int BYTE_W  = 8;
    localparam int COUNT_W = 2 * BYTE_W;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/fan_tach_sync_filter.sv
// Synchronises one asynchronous tach input, then accepts a level change only
// after FILT_LEN consecutive clocks at the new value. Emits a one-clock pulse
// (registered) when the accepted level rises.
// Assumes SYNC_STAGES >= 2 and FILT_LEN >= 1.
module fan_tach_sync_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tach_raw,
    output logic rise_pulse
);
    localparam int RUN_W = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   synced;
    logic [RUN_W-1:0]       run_q;
    logic                   level_q;
    logic                   rise_q;

    // Shift the raw input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], tach_raw};
    end

    assign synced = sync_q[SYNC_STAGES-1];

    // Count clocks of disagreement and commit the level once the run is long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= '0;
            level_q <= 1'b0;
            rise_q  <= 1'b0;
        end else begin
            rise_q <= 1'b0;
            if (synced == level_q) begin
                run_q <= '0;
            end else if (run_q == RUN_W'(FILT_LEN - 1)) begin
                level_q <= synced;
                run_q   <= '0;
                rise_q  <= synced;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign rise_pulse = rise_q;

    // The filtered level may only move toward the synchronised input.
    p_level_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level_q) |-> (level_q == $past(synced)));

    // A qualified rise is never followed directly by another one.
    p_single_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_q |=> !rise_q);
endmodule

// File: rtl/fan_tach_counter.sv
// Counts reference ticks between qualified rising tach edges and holds the
// completed count. Saturates at all-ones and then reports all-ones.
// Assumes rise_pulse is at most one clock wide.
module fan_tach_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             rise_pulse,
    output logic [CNT_W-1:0] held_count
);
    localparam logic [CNT_W-1:0] SAT = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] hold_q;

    // Restart on an edge, otherwise advance on ticks and saturate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            hold_q <= SAT;
        end else if (rise_pulse) begin
            hold_q <= cnt_q;
            cnt_q  <= {{(CNT_W-1){1'b0}}, tick_en};
        end else begin
            if (tick_en && cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
            if (cnt_q == SAT)            hold_q <= SAT;
        end
    end

    assign held_count = hold_q;

    p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == SAT && !rise_pulse) |=> (cnt_q == SAT));

    p_stall_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == SAT && !rise_pulse) |=> (hold_q == SAT));

    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> (hold_q == $past(cnt_q)));

    p_tick_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !rise_pulse) |=> $stable(cnt_q));
endmodule

// File: rtl/fan_tach_regfile.sv
// Index/data register window onto the held counts. A low-byte read latches
// the matching high byte into a shadow; high-byte reads return the shadow.
// Assumes the base index is even and counts are two bytes wide.
module fan_tach_regfile
    import fan_tach_pkg::*;
#(
    parameter int NUM_CH    = 3,
    parameter int INDEX_OFS = 8'h70,
    parameter int DATA_OFS  = 8'h71,
    parameter int BASE_IDX  = 8'h28
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CH-1:0][COUNT_W-1:0] hold_i,
    input  byte_t                         reg_addr,
    input  logic                          reg_wr,
    input  logic                          reg_rd,
    input  byte_t                         reg_wdata,
    output byte_t                         reg_rdata
);
    byte_t               idx_q;
    byte_t               rdata_q;
    byte_t               data_byte;
    byte_t [NUM_CH-1:0]  shadow_q;
    logic  [NUM_CH-1:0]  lo_hit;
    logic  [NUM_CH-1:0]  hi_hit;
    logic                rd_data;
    logic                rd_index;

    assign rd_data  = reg_rd && (reg_addr == BYTE_W'(DATA_OFS));
    assign rd_index = reg_rd && (reg_addr == BYTE_W'(INDEX_OFS));

    // Decode the index into per-channel byte selects and pick the data byte.
    always_comb begin
        lo_hit    = '0;
        hi_hit    = '0;
        data_byte = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            lo_hit[k] = (idx_q == BYTE_W'(BASE_IDX + 2 * k));
            hi_hit[k] = (idx_q == BYTE_W'(BASE_IDX + 2 * k + 1));
            if (lo_hit[k]) data_byte = hold_i[k][BYTE_W-1:0];
            if (hi_hit[k]) data_byte = shadow_q[k];
        end
    end

    // Load the index register from the index port.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          idx_q <= '0;
        else if (reg_wr && reg_addr == BYTE_W'(INDEX_OFS))   idx_q <= reg_wdata;
    end

    // Latch each channel's high byte when its low byte is read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '1;
        end else begin
            for (int k = 0; k < NUM_CH; k++)
                if (rd_data && lo_hit[k]) shadow_q[k] <= hold_i[k][COUNT_W-1:BYTE_W];
        end
    end

    // Register read data on a read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)        rdata_q <= '0;
        else if (rd_index) rdata_q <= idx_q;
        else if (rd_data)  rdata_q <= data_byte;
        else if (reg_rd)   rdata_q <= '0;
    end

    assign reg_rdata = rdata_q;

    p_rdata_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

    p_other_ofs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !rd_index && !rd_data) |=> (reg_rdata == '0));

    p_unimpl_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && lo_hit == '0 && hi_hit == '0) |=> (reg_rdata == '0));

    for (genvar k = 0; k < NUM_CH; k++) begin : g_shadow_chk
        p_shadow_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_data && lo_hit[k]) |=> (shadow_q[k] == $past(hold_i[k][COUNT_W-1:BYTE_W])));
    end
endmodule

// File: rtl/fan_tach_monitor.sv
// Top level: one synchroniser/filter and one period counter per fan, and a
// shared index/data register window. Assumes tick_en is a one-clock enable.
module fan_tach_monitor
    import fan_tach_pkg::*;
#(
    parameter int NUM_FANS    = 3,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3,
    parameter int INDEX_OFS   = 8'h70,
    parameter int DATA_OFS    = 8'h71,
    parameter int BASE_IDX    = 8'h28
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic [NUM_FANS-1:0] tach_in,
    input  logic [7:0]          reg_addr,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata
);
    logic [NUM_FANS-1:0]              rise_w;
    logic [NUM_FANS-1:0][COUNT_W-1:0] hold_w;

    for (genvar k = 0; k < NUM_FANS; k++) begin : g_fan
        fan_tach_sync_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN)
        ) u_filt (
            .clk        (clk),
            .rst_n      (rst_n),
            .tach_raw   (tach_in[k]),
            .rise_pulse (rise_w[k])
        );

        fan_tach_counter #(
            .CNT_W (COUNT_W)
        ) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_en    (tick_en),
            .rise_pulse (rise_w[k]),
            .held_count (hold_w[k])
        );
    end

    fan_tach_regfile #(
        .NUM_CH    (NUM_FANS),
        .INDEX_OFS (INDEX_OFS),
        .DATA_OFS  (DATA_OFS),
        .BASE_IDX  (BASE_IDX)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_i    (hold_w),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );
endmodule

// File: tb/fan_tach_monitor_tb_top.sv
`timescale 1ns/1ps
module fan_tach_monitor_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [2:0] tach_in = '0;
    logic [7:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    string phase = "R1";

    int per[3]    = '{0, 0, 0};
    int ph[3]     = '{0, 0, 0};
    bit man[3]    = '{0, 0, 0};
    int tick_div  = 1;
    int tick_ctr  = 0;

    always #2 clk = ~clk;

    fan_tach_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tach_in(tach_in),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // Stimulus generators for tach waveforms and the tick enable
    always @(negedge clk) begin
        for (int k = 0; k < 3; k++) begin
            if (per[k] > 0) begin
                ph[k] = (ph[k] + 1) % per[k];
                tach_in[k] = (ph[k] < per[k] / 2);
            end else begin
                tach_in[k] = man[k];
            end
        end
        tick_ctr = (tick_ctr + 1) % tick_div;
        tick_en  = (tick_ctr == 0);
    end

    // Behavioural reference model
    int m_s1[3], m_s2[3], m_run[3], m_lvl[3], m_rise[3], m_cnt[3], m_hold[3], m_sh[3];
    int m_idx, m_rdata;
    bit started = 0;

    always @(posedge clk) begin
        int n_s1[3], n_s2[3], n_run[3], n_lvl[3], n_rise[3], n_cnt[3], n_hold[3], n_sh[3];
        int n_idx, n_rdata, byt;
        started = 1;
        if (!rst_n) begin
            for (int k = 0; k < 3; k++) begin
                m_s1[k] = 0; m_s2[k] = 0; m_run[k] = 0; m_lvl[k] = 0; m_rise[k] = 0;
                m_cnt[k] = 0; m_hold[k] = 65535; m_sh[k] = 255;
            end
            m_idx = 0; m_rdata = 0;
        end else begin
            byt = 0;
            for (int k = 0; k < 3; k++) begin
                n_s1[k] = tach_in[k]; n_s2[k] = m_s1[k];
                n_run[k] = m_run[k]; n_lvl[k] = m_lvl[k]; n_rise[k] = 0;
                if (m_s2[k] == m_lvl[k]) n_run[k] = 0;
                else if (m_run[k] == 2) begin n_lvl[k] = m_s2[k]; n_run[k] = 0; n_rise[k] = m_s2[k]; end
                else n_run[k] = m_run[k] + 1;
                if (m_rise[k] != 0) begin
                    n_hold[k] = m_cnt[k]; n_cnt[k] = tick_en ? 1 : 0;
                end else begin
                    n_cnt[k] = (tick_en && m_cnt[k] < 65535) ? m_cnt[k] + 1 : m_cnt[k];
                    n_hold[k] = (m_cnt[k] == 65535) ? 65535 : m_hold[k];
                end
                n_sh[k] = m_sh[k];
                if (m_idx == 'h28 + 2*k) begin
                    byt = m_hold[k] % 256;
                    if (reg_rd && reg_addr == 8'h71) n_sh[k] = m_hold[k] / 256;
                end
                if (m_idx == 'h29 + 2*k) byt = m_sh[k];
            end
            n_rdata = m_rdata;
            if (reg_rd) n_rdata = (reg_addr == 8'h70) ? m_idx : (reg_addr == 8'h71) ? byt : 0;
            n_idx = (reg_wr && reg_addr == 8'h70) ? int'(reg_wdata) : m_idx;
            m_s1 = n_s1; m_s2 = n_s2; m_run = n_run; m_lvl = n_lvl; m_rise = n_rise;
            m_cnt = n_cnt; m_hold = n_hold; m_sh = n_sh; m_idx = n_idx; m_rdata = n_rdata;
        end
    end

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (started && !done) begin
            n_tests++;
            if (int'(reg_rdata) != m_rdata) begin
                n_fail++;
                $display("FAIL %s model compare: reg_rdata actual 0x%02h expected 0x%02h",
                         phase, reg_rdata, m_rdata[7:0]);
            end
        end
    end

    task automatic check(input string req, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic set_index(input logic [7:0] i);
        @(negedge clk); reg_wr = 1; reg_addr = 8'h70; reg_wdata = i;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic read_at(input logic [7:0] a, output int v);
        @(negedge clk); reg_rd = 1; reg_addr = a;
        @(negedge clk); reg_rd = 0; v = int'(reg_rdata);
    endtask

    task automatic read_idx(input logic [7:0] i, output int v);
        set_index(i);
        read_at(8'h71, v);
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int v, v2;
        wait_clks(5);
        rst_n = 1;
        // R1: reset state
        @(negedge clk);
        check("R1 rdata after reset", int'(reg_rdata), 0);
        read_idx(8'h28, v); check("R1 low byte after reset", v, 'hFF);
        read_idx(8'h2D, v); check("R1 shadow after reset", v, 'hFF);
        // R2: index readback
        read_at(8'h70, v); check("R2 index readback", v, 'h2D);

        // R3: distinct periods, tick every clock
        phase = "R3";
        per[0] = 40; per[1] = 100; per[2] = 248;
        wait_clks(1000);
        read_idx(8'h28, v); read_idx(8'h29, v2); check("R3 fan0 count", v + 256*v2, 40);
        read_idx(8'h2A, v); read_idx(8'h2B, v2); check("R3 fan1 count", v + 256*v2, 100);
        read_idx(8'h2C, v); read_idx(8'h2D, v2); check("R3 fan2 count", v + 256*v2, 248);

        // R4: tick every fourth clock
        phase = "R4";
        tick_div = 4;
        wait_clks(1200);
        read_idx(8'h28, v); check("R4 fan0 quarter-rate", v, 10);
        read_idx(8'h2A, v); check("R4 fan1 quarter-rate", v, 25);
        read_idx(8'h2C, v); check("R4 fan2 quarter-rate", v, 62);
        tick_div = 1;

        // R7: shadow coherence across a period change
        phase = "R7";
        per[1] = 300;
        wait_clks(1000);
        read_idx(8'h2A, v); check("R7 fan1 low before change", v, 'h2C);
        per[1] = 600;
        wait_clks(1500);
        read_idx(8'h2B, v); check("R7 high from shadow, not live", v, 'h01);
        read_idx(8'h2A, v); check("R7 fan1 low after change", v, 'h58);
        read_idx(8'h2B, v); check("R7 high after fresh low read", v, 'h02);

        // R6: glitches below the filter length are ignored
        phase = "R6";
        per[0] = 0; man[0] = 0;
        wait_clks(20);
        for (int g = 0; g < 5; g++) begin
            man[0] = 1; wait_clks(2);
            man[0] = 0; wait_clks(10);
        end
        read_idx(8'h28, v); check("R6 glitches keep held count", v, 40);
        man[0] = 1; wait_clks(6); man[0] = 0; wait_clks(10);
        read_idx(8'h28, v); n_tests++;
        if (v == 40) begin
            n_fail++;
            $display("FAIL R6 qualified pulse: actual 0x%0h expected not 0x28", v);
        end

        // R8: unimplemented indices, foreign offsets, ignored data writes
        phase = "R8";
        read_idx(8'h30, v); check("R8 unimplemented index 0x30", v, 0);
        read_idx(8'h27, v); check("R8 unimplemented index 0x27", v, 0);
        read_at(8'h72, v);  check("R8 foreign offset", v, 0);
        set_index(8'h2A);
        @(negedge clk); reg_wr = 1; reg_addr = 8'h71; reg_wdata = 8'h00;
        @(negedge clk); reg_wr = 0;
        read_at(8'h71, v);  check("R8 data-port write ignored", v, 'h58);

        // R9: read data holds without a read strobe
        phase = "R9";
        v2 = int'(reg_rdata);
        wait_clks(8);
        check("R9 rdata held", int'(reg_rdata), v2);

        // R5: stalled fan saturates
        phase = "R5";
        per[2] = 0; man[2] = 0;
        wait_clks(66000);
        read_idx(8'h2C, v); read_idx(8'h2D, v2); check("R5 stalled fan2 all-ones", v + 256*v2, 65535);
        wait_clks(50);
        read_idx(8'h2C, v); check("R5 no wrap after saturation", v, 'hFF);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule